// File: doc/BRIEF.md
# Dual Line Prefetch Queue

This block sits at the front of an instruction pipeline. It keeps two 16-byte line buffers stocked from a memory or cache read port, and shows the oldest unconsumed bytes to the first decode stage through a three-byte window. The decoder takes between zero and three bytes each cycle, according to how long the instruction it has recognised turns out to be. The buffers are used in ping-pong fashion. As soon as the decoder has taken every byte of one buffer, that buffer is requested again from memory. This refill runs on its own and does not wait on decode or execute.

A taken branch raises a flush together with the new fetch address. Both buffers are discarded. Fetching restarts at the 16-byte line that contains the target, and the read position is set to the target's low four bits. Only one memory read is in flight at a time. If a read is still in flight when a flush arrives, its data is thrown away when it returns.

Top module: `fetch_byte_queue`

## Requirements
- R1: While reset is held, and in the first cycle after it, the window shows no valid byte. The memory request is asserted for the line at the boot address, aligned down to 16 bytes.
- R2: Every memory request addresses a 16-byte aligned line. A request is accepted in each cycle in which it is high. No new request is raised while a read is still in flight, and none is raised in a cycle in which flush is high.
- R3: Window byte k sits on bits [8k+7:8k] and is the byte k places after the queue head. The valid flags are contiguous from bit 0. The consume count never exceeds the number of valid flags set, and it advances the head by that many bytes.
- R4: After a flush, window byte 0 is the byte at the flush address, once its line has arrived.
- R5: A single consume can cross from one buffer into the other. The window can also straddle the boundary, showing the end of one line and the start of the next.
- R6: With no consumption, prefetch stops after exactly two lines. In the cycle after the last byte of a buffer is consumed, a request is raised for the line after the newest one held.
- R7: In the cycle after a flush, the window shows no valid byte.
- R8: Read data that returns for a request issued before a flush is dropped. The window stays empty, and the request for the new line follows in the next cycle.
- R9: When flush is low, no read data returns and the consume count is zero, the window data and valid flags keep their values.
- R10: Byte i of a returned line (bits [8i+7:8i] of the read data) is the byte at the line address plus i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Taken branch: discard buffered bytes |
| flush_addr_i | input | ADDR_W | New fetch address that goes with flush_i |
| consume_i | input | 2 | Bytes taken by decode this cycle (0 to 3) |
| mem_req_o | output | 1 | Line read request, accepted whenever it is high |
| mem_addr_o | output | ADDR_W | Aligned line address of the request |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | LINE_BYTES*8 | Returned line, lowest address in the low byte |
| win_data_o | output | WIN_BYTES*8 | Bytes at the queue head, byte 0 lowest |
| win_valid_o | output | WIN_BYTES | Per-byte valid flags for the window |

## Verification
The assertions take certain things for granted about the inputs. Decode never asks for more bytes than the window marks valid. Read data comes back only for a request that is in flight, at least one cycle after that request was accepted. Consume is zero in a flush cycle. The bench's decoder driver waits until enough bytes are valid before it sets a count, and holds the count at zero around each flush. Its memory model accepts a request only when one is raised and returns exactly one line after a latency of at least one cycle. The latency is varied, and stretched far enough that a flush lands while a read is in flight.

// File: rtl/fbq_pkg.sv
package fbq_pkg;
  localparam int NBUF = 2;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/fbq_store.sv
module fbq_store
  import fbq_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  localparam int IDX_W = $clog2(NBUF)
) (
  input  logic                                 clk,
  input  logic                                 wr_en_i,
  input  logic [IDX_W-1:0]                     wr_idx_i,
  input  logic [LINE_BYTES*8-1:0]              wr_line_i,
  output logic [NBUF-1:0][LINE_BYTES-1:0][7:0] lines_o
);
  for (genvar g = 0; g < NBUF; g++) begin : g_buf
    logic [LINE_BYTES-1:0][7:0] line_q;
    logic                       line_en;
    assign line_en = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (line_en) line_q <= wr_line_i;
    end
    assign lines_o[g] = line_q;
  end
endmodule

// File: rtl/fbq_ctrl.sv
module fbq_ctrl
  import fbq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int CONS_W     = 2,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SUM_W = OFF_W + 1,
  localparam int IDX_W = $clog2(NBUF),
  localparam int CNT_W = $clog2(NBUF + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic [ADDR_W-1:0] flush_addr_i,
  input  logic [CONS_W-1:0] consume_i,
  input  logic              rvalid_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [IDX_W-1:0]  head_o,
  output logic [CNT_W-1:0]  fill_o,
  output logic [OFF_W-1:0]  off_o
);
  logic [IDX_W-1:0]  head_q, head_d;
  logic [CNT_W-1:0]  fill_q, fill_d;
  logic [OFF_W-1:0]  off_q, off_d;
  logic              pend_q, pend_d;
  logic              drop_q, drop_d;
  logic [ADDR_W-1:0] fetch_q, fetch_d;
  logic              fetch_en, ptr_en;
  logic              req, accept, pop;
  logic [SUM_W-1:0]  sum;

  always_comb begin
    req      = !pend_q && (fill_q < CNT_W'(NBUF)) && !flush_i;
    accept   = rvalid_i && pend_q && !drop_q && !flush_i;
    sum      = {1'b0, off_q} + SUM_W'(consume_i);
    pop      = !flush_i && (sum >= SUM_W'(LINE_BYTES));
    ptr_en   = flush_i || (consume_i != '0) || accept;
    fetch_en = flush_i || req;

    head_d = pop ? head_q + IDX_W'(1) : head_q;
    fill_d = fill_q + CNT_W'(accept) - CNT_W'(pop);
    off_d  = pop ? OFF_W'(sum - SUM_W'(LINE_BYTES)) : sum[OFF_W-1:0];
    if (flush_i) begin
      head_d = '0;
      fill_d = '0;
      off_d  = flush_addr_i[OFF_W-1:0];
    end

    pend_d = req ? 1'b1 : (rvalid_i ? 1'b0 : pend_q);
    drop_d = rvalid_i ? 1'b0 : ((flush_i && pend_q) ? 1'b1 : drop_q);

    fetch_d = flush_i ? {flush_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}
                      : fetch_q + ADDR_W'(LINE_BYTES);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      fill_q  <= '0;
      off_q   <= BOOT_ADDR[OFF_W-1:0];
      pend_q  <= 1'b0;
      drop_q  <= 1'b0;
      fetch_q <= {BOOT_ADDR[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
    end else begin
      if (ptr_en) begin
        head_q <= head_d;
        fill_q <= fill_d;
        off_q  <= off_d;
      end
      pend_q <= pend_d;
      drop_q <= drop_d;
      if (fetch_en) fetch_q <= fetch_d;
    end
  end

  assign req_o    = req;
  assign addr_o   = fetch_q;
  assign wr_en_o  = accept;
  assign wr_idx_o = head_q + IDX_W'(fill_q);
  assign head_o   = head_q;
  assign fill_o   = fill_q;
  assign off_o    = off_q;

  p_req_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (addr_o[OFF_W-1:0] == '0));

  p_single_outstanding_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |=> !req_o);

  p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_o == CNT_W'(NBUF)) |-> !req_o);

  p_stale_kept_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_q && rvalid_i) |-> !wr_en_o);
endmodule

// File: rtl/fbq_window.sv
module fbq_window
  import fbq_pkg::*;
#(
  parameter int LINE_BYTES = 16,
  parameter int WIN_BYTES  = 3,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int SUM_W = OFF_W + 1,
  localparam int IDX_W = $clog2(NBUF),
  localparam int CNT_W = $clog2(NBUF + 1)
) (
  input  logic [NBUF-1:0][LINE_BYTES-1:0][7:0] lines_i,
  input  logic [IDX_W-1:0]                     head_i,
  input  logic [CNT_W-1:0]                     fill_i,
  input  logic [OFF_W-1:0]                     off_i,
  output logic [WIN_BYTES*8-1:0]               data_o,
  output logic [WIN_BYTES-1:0]                 valid_o
);
  for (genvar k = 0; k < WIN_BYTES; k++) begin : g_slot
    logic [SUM_W-1:0] pos;
    logic             nxt;
    logic [IDX_W-1:0] bsel;
    logic [OFF_W-1:0] bidx;
    always_comb begin
      pos  = {1'b0, off_i} + SUM_W'(k);
      nxt  = pos >= SUM_W'(LINE_BYTES);
      bsel = head_i + IDX_W'(nxt);
      bidx = nxt ? OFF_W'(pos - SUM_W'(LINE_BYTES)) : pos[OFF_W-1:0];
    end
    assign valid_o[k]       = fill_i > CNT_W'(nxt);
    assign data_o[8*k +: 8] = lines_i[bsel][bidx];
  end
endmodule

// File: rtl/fetch_byte_queue.sv
module fetch_byte_queue
  import fbq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 16,
  parameter int WIN_BYTES  = 3,
  parameter logic [ADDR_W-1:0] BOOT_ADDR = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flush_i,
  input  logic [ADDR_W-1:0]                 flush_addr_i,
  input  logic [$clog2(WIN_BYTES+1)-1:0]    consume_i,
  output logic                              mem_req_o,
  output logic [ADDR_W-1:0]                 mem_addr_o,
  input  logic                              mem_rvalid_i,
  input  logic [LINE_BYTES*8-1:0]           mem_rdata_i,
  output logic [WIN_BYTES*8-1:0]            win_data_o,
  output logic [WIN_BYTES-1:0]              win_valid_o
);
  localparam int CONS_W = $clog2(WIN_BYTES + 1);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NBUF);
  localparam int CNT_W  = $clog2(NBUF + 1);

  logic                                 wr_en;
  logic [IDX_W-1:0]                     wr_idx, head;
  logic [CNT_W-1:0]                     fill;
  logic [OFF_W-1:0]                     off;
  logic [NBUF-1:0][LINE_BYTES-1:0][7:0] lines;

  fbq_ctrl #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .CONS_W(CONS_W), .BOOT_ADDR(BOOT_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .consume_i(consume_i), .rvalid_i(mem_rvalid_i), .req_o(mem_req_o),
    .addr_o(mem_addr_o), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .head_o(head),
    .fill_o(fill), .off_o(off)
  );

  fbq_store #(.LINE_BYTES(LINE_BYTES)) u_store (
    .clk(clk), .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_line_i(mem_rdata_i),
    .lines_o(lines)
  );

  fbq_window #(.LINE_BYTES(LINE_BYTES), .WIN_BYTES(WIN_BYTES)) u_win (
    .lines_i(lines), .head_i(head), .fill_i(fill), .off_i(off),
    .data_o(win_data_o), .valid_o(win_valid_o)
  );

  p_consume_within_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(consume_i) <= $countones(win_valid_o));

  p_valid_contig_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (win_valid_o & (win_valid_o + WIN_BYTES'(1))) == '0);

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (win_valid_o == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush_i && !mem_rvalid_i && consume_i == '0) |=>
      ($stable(win_valid_o) && $stable(win_data_o)));
endmodule

// File: tb/test_fetch_byte_queue.sv
`timescale 1ns/1ps
module test_fetch_byte_queue;
  localparam int LB = 16;
  localparam int WB = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          flush_i = 1'b0;
  logic [31:0]   flush_addr_i = '0;
  logic [1:0]    consume_i = '0;
  logic          mem_req_o;
  logic [31:0]   mem_addr_o;
  logic          mem_rvalid_i = 1'b0;
  logic [LB*8-1:0] mem_rdata_i = '0;
  logic [WB*8-1:0] win_data_o;
  logic [WB-1:0]   win_valid_o;

  fetch_byte_queue i_fetch_byte_queue (
    .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .flush_addr_i(flush_addr_i),
    .consume_i(consume_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
    .win_data_o(win_data_o), .win_valid_o(win_valid_o)
  );

  always #4 clk = ~clk;

  int nvec = 0, nfail = 0;
  int mem_lat = 2, mcnt = 0, req_cnt = 0;
  bit mem_out = 0, first = 0, done = 0;
  logic [31:0] maddr, exp_ptr = '0;
  logic [7:0] exp_q[$];

  function automatic logic [7:0] pat(input logic [31:0] a);
    logic [7:0] lo;
    lo = a[7:0];
    return (lo * 8'd7) ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic int vcnt();
    return $countones(win_valid_o);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // memory model: accepts each raised request, answers after mem_lat cycles (R2, R10)
  initial begin
    forever begin
      @(negedge clk); #2;
      mem_rvalid_i = 1'b0;
      if (mcnt > 0) begin
        mcnt--;
        if (mcnt == 0) begin
          mem_rvalid_i = 1'b1;
          for (int i = 0; i < LB; i++) mem_rdata_i[8*i +: 8] = pat(maddr + 32'(i));
          mem_out = 0;
        end
      end
      if (rst_n && mem_req_o) begin
        chk(!mem_out && mem_addr_o[3:0] == 4'h0, "R2", mem_addr_o, {mem_addr_o[31:4], 4'h0});
        maddr = mem_addr_o;
        mcnt = mem_lat;
        mem_out = 1;
        req_cnt++;
      end
    end
  end

  // monitor: pops expected bytes as decode consumes them (R3, R4, R10)
  initial begin
    forever begin
      @(negedge clk); #1;
      for (int k = 0; k < int'(consume_i); k++) begin
        if (exp_q.size() == 0) chk(1'b0, "R3", 32'(k), 32'hFFFF);
        else begin
          logic [7:0] e;
          e = exp_q.pop_front();
          chk(win_data_o[8*k +: 8] == e, first ? "R4" : "R3", win_data_o[8*k +: 8], e);
          first = 0;
        end
      end
    end
  end

  task automatic take(input int n);
    int guard = 0;
    while (vcnt() < n) begin
      consume_i = '0;
      @(negedge clk);
      guard++;
      if (guard > 500) begin
        chk(1'b0, "R6", 32'(vcnt()), 32'(n));
        return;
      end
    end
    for (int k = 0; k < n; k++) exp_q.push_back(pat(exp_ptr + 32'(k)));
    exp_ptr = exp_ptr + 32'(n);
    consume_i = 2'(n);
    @(negedge clk);
    consume_i = '0;
  endtask

  task automatic do_flush(input logic [31:0] a);
    flush_i = 1'b1;
    flush_addr_i = a;
    @(negedge clk);
    flush_i = 1'b0;
    chk(win_valid_o == '0, "R7", 32'(win_valid_o), 0);
    exp_q.delete();
    exp_ptr = a;
    first = 1;
    req_cnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
  end

  initial begin
    logic [WB*8-1:0] snap_d;
    logic [WB-1:0]   snap_v;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(win_valid_o == '0, "R1", 32'(win_valid_o), 0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    chk(win_valid_o == '0, "R1", 32'(win_valid_o), 0);
    chk(mem_req_o && mem_addr_o == 32'h0, "R1", mem_addr_o, 0);

    // streams from boot address, varied consume sizes and latencies (R3, R10)
    for (int i = 0; i < 45; i++) take((i % 3) + 1);
    mem_lat = 1;
    for (int i = 0; i < 30; i++) take(3 - (i % 3));
    mem_lat = 3;
    for (int i = 0; i < 20; i++) take(1 + ((i / 2) % 3));

    // R4: flush to unaligned target
    mem_lat = 2;
    do_flush(32'h0000_1237);
    for (int i = 0; i < 12; i++) take(2);

    // R6: two lines then stop; refill right after a buffer drains
    do_flush(32'h0000_0300);
    repeat (30) @(negedge clk);
    chk(req_cnt == 2, "R6", 32'(req_cnt), 2);
    chk(!mem_req_o, "R6", 32'(mem_req_o), 0);
    for (int i = 0; i < 5; i++) take(3);
    chk(!mem_req_o, "R6", 32'(mem_req_o), 0);
    take(1);
    chk(mem_req_o && mem_addr_o == 32'h320, "R6", mem_addr_o, 32'h320);

    // R5 and R9: straddling window, hold, crossing consume
    do_flush(32'h0000_020E);
    repeat (30) @(negedge clk);
    chk(vcnt() == 3, "R5", 32'(vcnt()), 3);
    snap_d = win_data_o;
    snap_v = win_valid_o;
    repeat (6) @(negedge clk);
    chk(win_data_o == snap_d && win_valid_o == snap_v, "R9", win_data_o, snap_d);
    chk(req_cnt == 2, "R9", 32'(req_cnt), 2);
    take(3);
    take(3);
    chk(win_data_o[7:0] == pat(32'h214), "R5", win_data_o[7:0], pat(32'h214));
    take(2);

    // R8: flush while a read is in flight
    repeat (10) @(negedge clk);
    mem_lat = 8;
    do_flush(32'h0000_0500);
    repeat (3) @(negedge clk);
    chk(mem_out, "R8", 32'(mem_out), 1);
    do_flush(32'h0000_07A5);
    for (int g = 0; g < 40; g++) begin
      @(negedge clk); #3;
      if (mem_rvalid_i) break;
      chk(!mem_req_o, "R8", 32'(mem_req_o), 0);
    end
    mem_lat = 2;
    @(negedge clk); #3;
    chk(win_valid_o == '0, "R8", 32'(win_valid_o), 0);
    chk(mem_req_o && mem_addr_o == 32'h7A0, "R8", mem_addr_o, 32'h7A0);
    for (int i = 0; i < 25; i++) take((i % 3) + 1);

    repeat (5) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule